// File: doc/BRIEF.md
# Dual Decade Counter with Selectable Stage Chaining

The block holds two identical counting halves. Each half is built from a divide-by-2 stage and a divide-by-5 stage, and each stage has its own section clock input. A stage advances on the falling edge of its section clock. Each half also has its own clear input, which forces that half to zero and holds it there. All state sits in registers on one system clock. The section clocks are treated as slow data: each one is synchronized and then edge-detected, and a detected falling edge enables a single step of its stage.

A shared mode input sets how the two stages inside each half are linked:
- **Decimal mode.** A falling divide-by-2 output steps the divide-by-5 stage in the same cycle, so the half counts 0 to 9 in BCD.
- **Two-five mode.** The top bit of the divide-by-5 stage steps the divide-by-2 stage, so bit 0 becomes a square wave at one tenth of the input rate.
- **Independent mode.** The two stages stay unlinked, so external wiring can build divide ratios of 2, 4, 5, 10, 20, 25, 50 or 100. For example, feeding one half's bit 3 into the other half's first section clock gives two-digit decimal counting.

Top module: `dual_decade_counter`

## Requirements
- R1: After the synchronous reset `rst`, every output bit is 0.
- R2: In independent mode (`mode` 2'b00 or 2'b11), each falling edge of a half's `cp0` toggles that half's bit 0 exactly once. A rising edge has no effect.
- R3: Bits 3:1 of a half form a plain binary count 0,1,2,3,4,0. In independent mode it steps once per falling edge of that half's `cp1`, and it never holds a value above 4.
- R4: In decimal mode (`mode` 2'b01), after n falling edges on `cp0` the half's nibble equals n mod 10 in binary. Edges on `cp1` are ignored.
- R5: In two-five mode (`mode` 2'b10), after n falling edges on `cp1`, bits 3:1 equal n mod 5 and bit 0 equals (n div 5) mod 2. This makes bit 0 high for five inputs and low for five. Edges on `cp0` are ignored.
- R6: While a half's `clr` bit is high, that half reads zero from the next clock edge onward, whatever its section clocks do. The other half is unaffected.
- R7: After `clr` is released, the first falling edge on the stepping clock moves the half from zero to one.
- R8: With both halves in decimal mode and half 1's `cp0` driven by half 0's bit 3, the pair counts 00 to 99 in BCD and then wraps. Half 1's bit 3 then falls once per 100 input edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset of all state |
| mode | input | 2 | Chaining select: 00/11 independent, 01 decimal, 10 two-five |
| cp0 | input | 2 | Divide-by-2 section clock, one bit per half |
| cp1 | input | 2 | Divide-by-5 section clock, one bit per half |
| clr | input | 2 | Active-high clear, one bit per half |
| q | output | 8 | Half h occupies bits 4h+3:4h; bit 0 is the divide-by-2 output, bits 3:1 the divide-by-5 count |

## Verification
The bench runs long runs of falling edges in each mode and compares the nibble with values it derives by arithmetic from the edge count. Several kinds of error are separated this way:
- Two and a half decades in decimal mode expose a carry that fires on the wrong edge.
- Four cycles in two-five mode expose a wrong duty on bit 0.
- Two hundred edges through the cascaded pair expose a missed tens carry.

Other stimuli target specific faults. Edges on the unused section clock in each mode show up any leak from a clock that should be ignored. Independent-mode sweeps use held-high inputs to catch rising-edge counting. A clear applied to one half while the other half holds a nonzero value catches a clear that spreads or is released too early.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  localparam int QUIN_MOD = 5;
  localparam int QUIN_W   = $clog2(QUIN_MOD);
  localparam int HALF_W   = QUIN_W + 1;

  typedef enum logic [1:0] {
    LINK_NONE  = 2'b00,
    LINK_DEC   = 2'b01,
    LINK_BIQ   = 2'b10,
    LINK_NONE2 = 2'b11
  } link_e;
endpackage

// File: rtl/dcr_fall_detect.sv
module dcr_fall_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic fall
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q[0] <= din;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign fall = prev_q & ~sync_q[SYNC_STAGES-1];

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall); // R2
endmodule

// File: rtl/dcr_toggle_stage.sv
module dcr_toggle_stage (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic adv,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= 1'b0;
    else if (adv)   q <= ~q;
  end
endmodule

// File: rtl/dcr_quinary_stage.sv
module dcr_quinary_stage
  import dcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              adv,
  output logic [QUIN_W-1:0] cnt
);
  localparam logic [QUIN_W-1:0] LAST = QUIN_W'(QUIN_MOD - 1);

  always_ff @(posedge clk) begin
    if (rst || clr)        cnt <= '0;
    else if (adv) begin
      if (cnt >= LAST)     cnt <= '0;
      else                 cnt <= cnt + QUIN_W'(1);
    end
  end

  AST_QUIN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST); // R3
endmodule

// File: rtl/dcr_half.sv
module dcr_half
  import dcr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  link_e             link,
  input  logic              cp0,
  input  logic              cp1,
  input  logic              clr,
  output logic [HALF_W-1:0] q
);
  logic              fall_a, fall_b;
  logic              adv2, adv5;
  logic              bit0;
  logic [QUIN_W-1:0] quin;

  dcr_fall_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge_a (
    .clk(clk), .rst(rst), .din(cp0), .fall(fall_a));
  dcr_fall_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge_b (
    .clk(clk), .rst(rst), .din(cp1), .fall(fall_b));

  always_comb begin
    unique case (link)
      LINK_DEC: begin
        adv2 = fall_a;
        adv5 = fall_a & bit0;
      end
      LINK_BIQ: begin
        adv5 = fall_b;
        adv2 = fall_b & quin[QUIN_W-1];
      end
      default: begin
        adv2 = fall_a;
        adv5 = fall_b;
      end
    endcase
  end

  dcr_toggle_stage u_div2 (
    .clk(clk), .rst(rst), .clr(clr), .adv(adv2), .q(bit0));
  dcr_quinary_stage u_div5 (
    .clk(clk), .rst(rst), .clr(clr), .adv(adv5), .cnt(quin));

  assign q = {quin, bit0};

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clr |=> q == '0); // R6
  AST_DEC_WRAP: assert property (@(posedge clk) disable iff (rst)
    (link == LINK_DEC && !clr && fall_a && q == 4'd9) |=> q == '0); // R4
  AST_DEC_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (link == LINK_DEC && !clr && !fall_a) |=> $stable(q)); // R4
  AST_BIQ_WRAP: assert property (@(posedge clk) disable iff (rst)
    (link == LINK_BIQ && !clr && fall_b && q == 4'b1001) |=> q == '0); // R5
  AST_BIQ_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (link == LINK_BIQ && !clr && !fall_b) |=> $stable(q)); // R5
endmodule

// File: rtl/dual_decade_counter.sv
module dual_decade_counter
  import dcr_pkg::*;
#(
  parameter int NUM_HALVES  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [1:0]                   mode,
  input  logic [NUM_HALVES-1:0]        cp0,
  input  logic [NUM_HALVES-1:0]        cp1,
  input  logic [NUM_HALVES-1:0]        clr,
  output logic [NUM_HALVES*HALF_W-1:0] q
);
  link_e link;
  assign link = link_e'(mode);

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    dcr_half #(.SYNC_STAGES(SYNC_STAGES)) u_half (
      .clk (clk),
      .rst (rst),
      .link(link),
      .cp0 (cp0[h]),
      .cp1 (cp1[h]),
      .clr (clr[h]),
      .q   (q[h*HALF_W +: HALF_W])
    );
  end

  AST_RESET_ZERO: assert property (@(posedge clk)
    rst |=> q == '0); // R1
endmodule

// File: tb/dual_decade_counter_bench.sv
module dual_decade_counter_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'b00;
  logic [1:0] cp0_drv = 2'b00;
  logic [1:0] cp1 = 2'b00;
  logic [1:0] clr = 2'b00;
  logic       cascade = 1'b0;
  logic [1:0] cp0;
  logic [7:0] q;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  assign cp0 = {cascade ? q[3] : cp0_drv[1], cp0_drv[0]};

  dual_decade_counter u_dual_decade_counter (
    .clk(clk), .rst(rst), .mode(mode), .cp0(cp0), .cp1(cp1), .clr(clr), .q(q));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic pulse0(input int h);
    cp0_drv[h] = 1'b1; tick(3); cp0_drv[h] = 1'b0; tick(8);
  endtask

  task automatic pulse1(input int h);
    cp1[h] = 1'b1; tick(3); cp1[h] = 1'b0; tick(8);
  endtask

  task automatic full_clear();
    clr = 2'b11; tick(2); clr = 2'b00; tick(2);
  endtask

  initial begin
    tick(4);
    rst = 1'b0;
    tick(2);
    check("R1 reset", q, 8'h00);

    // R2: rising edge alone does nothing, falling edge toggles bit 0
    mode = 2'b00;
    cp0_drv[0] = 1'b1; tick(8);
    check("R2 rising ignored", q, 8'h00);
    cp0_drv[0] = 1'b0; tick(8);
    check("R2 falling toggles", q, 8'h01);
    for (int n = 2; n <= 5; n++) begin
      pulse0(0);
      check("R2 toggle count", q, 8'((n % 2)));
    end
    // R3: independent divide-by-5 count on half 1, mode 11 also independent
    mode = 2'b11;
    for (int n = 1; n <= 12; n++) begin
      pulse1(1);
      check("R3 quinary count", q, 8'(((n % 5) << 1)) << 4 | 8'h01);
    end

    // R4: decimal mode sweep on half 0
    mode = 2'b01;
    full_clear();
    for (int n = 1; n <= 25; n++) begin
      pulse0(0);
      check("R4 decimal count", q, 8'(n % 10));
    end
    pulse1(0);
    check("R4 cp1 ignored", q, 8'(25 % 10));

    // R5: two-five mode sweep on half 0
    mode = 2'b10;
    full_clear();
    begin
      int highs = 0;
      for (int n = 1; n <= 40; n++) begin
        pulse1(0);
        check("R5 two-five count", q, 8'((((n % 5) << 1) | ((n / 5) % 2))));
        if (q[0]) highs++;
      end
      checks++;
      if (highs != 20) begin
        errors++;
        $display("FAIL R5 duty: got %0d expected %0d", highs, 20);
      end
    end
    pulse0(0);
    check("R5 cp0 ignored", q, 8'h00);

    // R6/R7: clear one half while the other holds a value
    mode = 2'b00;
    full_clear();
    pulse0(0); pulse1(0); pulse1(0);
    pulse1(1);
    check("R6 setup", q, 8'h25);
    clr[0] = 1'b1; tick(2);
    check("R6 clear half 0", q, 8'h20);
    pulse0(0); pulse1(0);
    check("R6 held clear", q, 8'h20);
    clr[0] = 1'b0; tick(2);
    check("R6 after release", q, 8'h20);
    pulse0(0);
    check("R7 first edge", q, 8'h21);

    // R8: cascaded decimal pair
    mode = 2'b01;
    full_clear();
    cascade = 1'b1;
    tick(4);
    for (int n = 1; n <= 200; n++) begin
      pulse0(0);
      check("R8 cascade", q, {4'((n / 10) % 10), 4'(n % 10)});
    end
    cascade = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule